// File: doc/BRIEF.md
# AES Single-Round Datapath

This unit applies exactly one AES round to a 128-bit state word and registers the result. Each request carries a state operand, a 128-bit round key and an operation code. The code picks one of five variants: a full encryption round, the last encryption round (no column mixing), a full decryption round, the last decryption round, or a plain byte substitution through the forward S-box that ignores the key. A sequencer outside the block supplies the expanded keys and walks the rounds of a block. This unit handles only one round per request.

Bytes are numbered from the left, independent of any host byte order. Byte 0 occupies bits [127:120], and byte k occupies bits [127-8k:120-8k]. Byte k sits at state row k mod 4 and state column k div 4, so each group of four adjacent bytes forms one column. The unit takes a new request on every clock and returns the result one cycle later.

Top module: `aes_round_unit`

## Requirements
- R1: Byte k of a 128-bit operand is bits [127-8k:120-8k] and maps to state row k mod 4, column k div 4; a row rotation moves bytes between columns of the same row only.
- R2: Op code 0 (encrypt round) returns MixColumns(ShiftRows(SubBytes(in_state))) XOR in_key.
- R3: Op code 1 (encrypt last round) returns ShiftRows(SubBytes(in_state)) XOR in_key.
- R4: Op code 2 (decrypt round) returns InvMixColumns(InvSubBytes(InvShiftRows(in_state)) XOR in_key).
- R5: Op code 3 (decrypt last round) returns InvSubBytes(InvShiftRows(in_state)) XOR in_key, so it undoes op code 1 when both use a zero key.
- R6: Op code 4 (substitute only) replaces every byte of in_state with its forward S-box value (for example 0x00 becomes 0x63 and 0x53 becomes 0xED), and in_key has no effect on the result.
- R7: Op codes 5, 6 and 7 return in_state unchanged.
- R8: out_valid is high in the cycle after each cycle in which in_valid is high, and is low otherwise. Requests on consecutive cycles each produce their own result.
- R9: While out_valid is low, out_state keeps the last result it showed.
- R10: During reset, out_valid and out_state are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset, synchronous |
| in_valid | input | 1 | Request strobe |
| in_mode | input | 3 | Operation code (0..4 defined, 5..7 pass-through) |
| in_state | input | 128 | State operand, byte 0 leftmost |
| in_key | input | 128 | Round key operand |
| out_valid | output | 1 | Result strobe, one cycle after the request |
| out_state | output | 128 | Registered round result |

## Verification
The byte numbering is the hardest property to observe at the ports, because a uniform state or key hides any mistake in row rotation or column grouping. The bench therefore places one marked byte in a zero state and checks where it lands, both under substitute-only and under the last encryption round. It then sweeps all 256 byte values through the substitution path and checks encrypt/decrypt last-round pairs for round trips. Random operands in every op code are compared against a model built from a brute-force field inverse. Back-to-back requests followed by idle cycles exercise the latency and hold rules.

// File: rtl/aes_rnd_pkg.sv
package aes_rnd_pkg;

    localparam int BLK_W   = 128;
    localparam int BYTE_W  = 8;
    localparam int NBYTES  = BLK_W / BYTE_W;
    localparam int NROWS   = 4;
    localparam int NCOLS   = NBYTES / NROWS;
    localparam int COL_W   = NROWS * BYTE_W;
    localparam int OP_W    = 3;

    typedef enum logic [OP_W-1:0] {
        OP_ENC      = 3'd0,
        OP_ENC_LAST = 3'd1,
        OP_DEC      = 3'd2,
        OP_DEC_LAST = 3'd3,
        OP_SUB      = 3'd4
    } op_e;

    typedef struct packed {
        logic             valid;
        logic [BLK_W-1:0] data;
    } res_reg_t;

    // GF(2^8) product, reduction polynomial x^8+x^4+x^3+x+1
    function automatic logic [7:0] gf_mul(input logic [7:0] x, input logic [7:0] y);
        logic [7:0] acc;
        logic [7:0] sh;
        acc = 8'h00;
        sh  = x;
        for (int i = 0; i < 8; i++) begin
            if (y[i]) acc = acc ^ sh;
            sh = {sh[6:0], 1'b0} ^ (sh[7] ? 8'h1b : 8'h00);
        end
        return acc;
    endfunction

    // multiplicative inverse as x^254 (maps 0 to 0)
    function automatic logic [7:0] gf_inv(input logic [7:0] x);
        logic [7:0] r;
        r = 8'h01;
        for (int i = 7; i >= 0; i--) begin
            r = gf_mul(r, r);
            if (i != 0) r = gf_mul(r, x);
        end
        return r;
    endfunction

    function automatic logic [7:0] rotl8(input logic [7:0] x, input int n);
        return (x << n) | (x >> (8 - n));
    endfunction

    function automatic logic [7:0] affine_fwd(input logic [7:0] x);
        return x ^ rotl8(x, 1) ^ rotl8(x, 2) ^ rotl8(x, 3) ^ rotl8(x, 4) ^ 8'h63;
    endfunction

    function automatic logic [7:0] affine_inv(input logic [7:0] x);
        return rotl8(x, 1) ^ rotl8(x, 3) ^ rotl8(x, 6) ^ 8'h05;
    endfunction

endpackage

// File: rtl/aes_sbox_lane.sv
module aes_sbox_lane
    import aes_rnd_pkg::*;
#(
    parameter bit INVERSE = 1'b0
) (
    input  logic [BYTE_W-1:0] lane_i,
    output logic [BYTE_W-1:0] lane_o
);

    generate
        if (INVERSE) begin : g_inv
            always_comb begin
                lane_o = gf_inv(affine_inv(lane_i));
            end
        end else begin : g_fwd
            always_comb begin
                lane_o = affine_fwd(gf_inv(lane_i));
            end
        end
    endgenerate

    // R6: neither S-box direction has a fixed or complement-fixed point
    always_comb begin
        // R6
        sbox_no_fixed_point_chk: assert (lane_o != lane_i && lane_o != ~lane_i);
    end

endmodule

// File: rtl/aes_mix_col.sv
module aes_mix_col
    import aes_rnd_pkg::*;
#(
    parameter bit INVERSE = 1'b0
) (
    input  logic [COL_W-1:0] col_i,
    output logic [COL_W-1:0] col_o
);

    localparam logic [7:0] C0 = INVERSE ? 8'h0e : 8'h02;
    localparam logic [7:0] C1 = INVERSE ? 8'h0b : 8'h03;
    localparam logic [7:0] C2 = INVERSE ? 8'h0d : 8'h01;
    localparam logic [7:0] C3 = INVERSE ? 8'h09 : 8'h01;

    logic [BYTE_W-1:0] s [NROWS];

    generate
        for (genvar r = 0; r < NROWS; r++) begin : g_split
            assign s[r] = col_i[COL_W-1-BYTE_W*r -: BYTE_W];
        end
        for (genvar r = 0; r < NROWS; r++) begin : g_row
            always_comb begin
                col_o[COL_W-1-BYTE_W*r -: BYTE_W] =
                    gf_mul(C0, s[r])               ^
                    gf_mul(C1, s[(r + 1) % NROWS]) ^
                    gf_mul(C2, s[(r + 2) % NROWS]) ^
                    gf_mul(C3, s[(r + 3) % NROWS]);
            end
        end
    endgenerate

endmodule

// File: rtl/aes_round_unit.sv
module aes_round_unit
    import aes_rnd_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [2:0]       in_mode,
    input  logic [127:0]     in_state,
    input  logic [127:0]     in_key,
    output logic             out_valid,
    output logic [127:0]     out_state
);

    logic [BLK_W-1:0] rot_f;    // ShiftRows(in_state)
    logic [BLK_W-1:0] rot_i;    // InvShiftRows(in_state)
    logic [BLK_W-1:0] sub_f;    // forward S-box lanes
    logic [BLK_W-1:0] sub_i;    // inverse S-box lanes
    logic [BLK_W-1:0] dec_pre;  // inverse substitution XOR key
    logic [BLK_W-1:0] mix_f;
    logic [BLK_W-1:0] mix_i;
    logic [BLK_W-1:0] result;

    res_reg_t res_d, res_q;

    // byte rotation and substitution lanes
    generate
        for (genvar k = 0; k < NBYTES; k++) begin : g_byte
            localparam int ROW   = k % NROWS;
            localparam int COL   = k / NROWS;
            localparam int SRC_F = NROWS * ((COL + ROW) % NCOLS) + ROW;
            localparam int SRC_I = NROWS * ((COL - ROW + NCOLS) % NCOLS) + ROW;

            logic [BYTE_W-1:0] fwd_in;

            assign rot_f[BLK_W-1-BYTE_W*k -: BYTE_W] = in_state[BLK_W-1-BYTE_W*SRC_F -: BYTE_W];
            assign rot_i[BLK_W-1-BYTE_W*k -: BYTE_W] = in_state[BLK_W-1-BYTE_W*SRC_I -: BYTE_W];
            assign fwd_in = (in_mode == OP_SUB) ? in_state[BLK_W-1-BYTE_W*k -: BYTE_W]
                                                : rot_f[BLK_W-1-BYTE_W*k -: BYTE_W];

            aes_sbox_lane #(.INVERSE(1'b0)) i_sb_f (
                .lane_i (fwd_in),
                .lane_o (sub_f[BLK_W-1-BYTE_W*k -: BYTE_W])
            );
            aes_sbox_lane #(.INVERSE(1'b1)) i_sb_i (
                .lane_i (rot_i[BLK_W-1-BYTE_W*k -: BYTE_W]),
                .lane_o (sub_i[BLK_W-1-BYTE_W*k -: BYTE_W])
            );
        end
    endgenerate

    assign dec_pre = sub_i ^ in_key;

    // column mixing, both directions
    generate
        for (genvar c = 0; c < NCOLS; c++) begin : g_col
            aes_mix_col #(.INVERSE(1'b0)) i_mc_f (
                .col_i (sub_f[BLK_W-1-COL_W*c -: COL_W]),
                .col_o (mix_f[BLK_W-1-COL_W*c -: COL_W])
            );
            aes_mix_col #(.INVERSE(1'b1)) i_mc_i (
                .col_i (dec_pre[BLK_W-1-COL_W*c -: COL_W]),
                .col_o (mix_i[BLK_W-1-COL_W*c -: COL_W])
            );
        end
    endgenerate

    always_comb begin
        case (in_mode)
            OP_ENC:      result = mix_f ^ in_key;
            OP_ENC_LAST: result = sub_f ^ in_key;
            OP_DEC:      result = mix_i;
            OP_DEC_LAST: result = dec_pre;
            OP_SUB:      result = sub_f;
            default:     result = in_state;
        endcase
    end

    always_comb begin
        res_d       = res_q;
        res_d.valid = in_valid;
        if (in_valid) begin
            res_d.data = result;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q <= '0;
        end else begin
            res_q <= res_d;
        end
    end

    assign out_valid = res_q.valid;
    assign out_state = res_q.data;

    // R8
    latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R8
    idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    // R9
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_state));

    // R7
    passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_mode > 3'd4) |=> out_state == $past(in_state));

endmodule

// File: tb/test_aes_round_unit.sv
module test_aes_round_unit;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [2:0]   in_mode = 3'd0;
    logic [127:0] in_state = '0;
    logic [127:0] in_key = '0;
    logic         out_valid;
    logic [127:0] out_state;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [7:0] sbt  [256];
    logic [7:0] isbt [256];

    always #5 clk = ~clk;

    aes_round_unit i_aes_round_unit (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_mode   (in_mode),
        .in_state  (in_state),
        .in_key    (in_key),
        .out_valid (out_valid),
        .out_state (out_state)
    );

    function automatic logic [7:0] mulx(input logic [7:0] x, input logic [7:0] y);
        logic [15:0] p = '0;
        for (int i = 0; i < 8; i++) if (y[i]) p = p ^ (16'(x) << i);
        for (int i = 15; i >= 8; i--) if (p[i]) p = p ^ (16'h011b << (i - 8));
        return p[7:0];
    endfunction

    function automatic logic [7:0] bget(input logic [127:0] v, input int k);
        return v[127-8*k -: 8];
    endfunction

    function automatic logic [127:0] mixall(input logic [127:0] v, input bit inv);
        logic [127:0] o = '0;
        logic [7:0] m [4];
        logic [7:0] s [4];
        if (inv) begin m[0]=8'h0e; m[1]=8'h0b; m[2]=8'h0d; m[3]=8'h09; end
        else     begin m[0]=8'h02; m[1]=8'h03; m[2]=8'h01; m[3]=8'h01; end
        for (int c = 0; c < 4; c++) begin
            for (int r = 0; r < 4; r++) s[r] = bget(v, 4*c + r);
            for (int r = 0; r < 4; r++) begin
                logic [7:0] acc = 8'h00;
                for (int j = 0; j < 4; j++) acc = acc ^ mulx(m[(j - r + 4) % 4], s[j]);
                o[127-8*(4*c+r) -: 8] = acc;
            end
        end
        return o;
    endfunction

    function automatic logic [127:0] model(input logic [2:0] op, input logic [127:0] a,
                                           input logic [127:0] k);
        logic [127:0] t = '0;
        for (int b = 0; b < 16; b++) begin
            int r = b % 4;
            int c = b / 4;
            case (op)
                3'd0, 3'd1: t[127-8*b -: 8] = sbt[bget(a, 4*((c + r) % 4) + r)];
                3'd2, 3'd3: t[127-8*b -: 8] = isbt[bget(a, 4*((c - r + 4) % 4) + r)];
                default:    t[127-8*b -: 8] = sbt[bget(a, b)];
            endcase
        end
        case (op)
            3'd0:    return mixall(t, 1'b0) ^ k;
            3'd1:    return t ^ k;
            3'd2:    return mixall(t ^ k, 1'b1);
            3'd3:    return t ^ k;
            3'd4:    return t;
            default: return a;
        endcase
    endfunction

    task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // drive one request at the falling edge; result sampled just after the next rise
    task automatic req(input logic [2:0] op, input logic [127:0] a, input logic [127:0] k,
                       output logic [127:0] res);
        @(negedge clk);
        in_valid = 1'b1; in_mode = op; in_state = a; in_key = k;
        @(posedge clk); #1;
        res = out_state;
        if (out_valid !== 1'b1) begin
            checks++; fails++;
            $display("FAIL R8 actual=%b expected=1", out_valid);
        end
    endtask

    task automatic idle();
        @(negedge clk);
        in_valid = 1'b0;
        in_mode = 3'd0;
        in_state = {4{32'hdeadbeef}};
        in_key = {4{32'h0badf00d}};
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [127:0] res, a, k, last, fin;
        // reference tables from brute-force inverse and bitwise affine map
        for (int x = 0; x < 256; x++) begin
            logic [7:0] inv = 8'h00;
            logic [7:0] s;
            for (int y = 1; y < 256; y++) if (mulx(8'(x), 8'(y)) == 8'h01) inv = 8'(y);
            for (int i = 0; i < 8; i++)
                s[i] = inv[i] ^ inv[(i+4)%8] ^ inv[(i+5)%8] ^ inv[(i+6)%8] ^ inv[(i+7)%8]
                       ^ ((8'h63 >> i) & 8'h01);
            sbt[x] = s;
        end
        for (int x = 0; x < 256; x++) isbt[sbt[x]] = 8'(x);

        // R10: reset state
        repeat (3) @(posedge clk);
        #1;
        check("R10 out_valid", {127'd0, out_valid}, 128'd0);
        check("R10 out_state", out_state, 128'd0);
        @(negedge clk); rst_n = 1'b1;

        // R6: fixed S-box values
        req(3'd4, {8'h53, 120'd0}, {4{32'h12345678}}, res);
        check("R6/R1 byte0 0x53", res, {8'hed, {15{8'h63}}});
        // R1: byte 5 (row 1, col 1) moves to byte 1 under row rotation
        a = '0; a[127-8*5 -: 8] = 8'h53;
        req(3'd1, a, '0, res);
        k = {16{8'h63}}; k[127-8*1 -: 8] = 8'hed;
        check("R1 row rotation", res, k);

        // R6: sweep all 256 byte values, key varied (no effect)
        for (int g = 0; g < 16; g++) begin
            a = '0;
            for (int b = 0; b < 16; b++) a[127-8*b -: 8] = 8'(16*g + b);
            req(3'd4, a, {$urandom, $urandom, $urandom, $urandom}, res);
            check("R6 sweep", res, model(3'd4, a, '0));
        end

        // R3/R5: last-round round trip with zero key
        for (int g = 0; g < 16; g++) begin
            a = {$urandom, $urandom, $urandom, $urandom};
            req(3'd1, a, '0, fin);
            check("R3 enc last", fin, model(3'd1, a, '0));
            req(3'd3, fin, '0, res);
            check("R5 round trip", res, a);
        end

        // R2..R5: random operands per op code
        for (int op = 0; op < 4; op++) begin
            for (int g = 0; g < 24; g++) begin
                a = {$urandom, $urandom, $urandom, $urandom};
                k = {$urandom, $urandom, $urandom, $urandom};
                req(3'(op), a, k, res);
                case (op)
                    0: check("R2 enc round", res, model(3'd0, a, k));
                    1: check("R3 enc last", res, model(3'd1, a, k));
                    2: check("R4 dec round", res, model(3'd2, a, k));
                    default: check("R5 dec last", res, model(3'd3, a, k));
                endcase
            end
        end

        // R7: undefined codes pass the state through
        for (int op = 5; op < 8; op++) begin
            a = {$urandom, $urandom, $urandom, $urandom};
            req(3'(op), a, {$urandom, $urandom, $urandom, $urandom}, res);
            check("R7 passthrough", res, a);
        end

        // R8: back-to-back requests, mixed codes, no gap
        for (int g = 0; g < 10; g++) begin
            a = {$urandom, $urandom, $urandom, $urandom};
            k = {$urandom, $urandom, $urandom, $urandom};
            req(3'(g % 8), a, k, res);
            check("R8 back-to-back", res, model(3'(g % 8), a, k));
            last = res;
        end

        // R8/R9: idle cycles clear out_valid and hold out_state
        idle();
        for (int g = 0; g < 4; g++) begin
            @(posedge clk); #1;
            check("R8 idle valid", {127'd0, out_valid}, 128'd0);
            check("R9 hold", out_state, last);
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule